// File: doc/BRIEF.md
# SDRAM Mode-Register Load Sequencer

This block sits inside a bus controller, between a CPU-style byte write port and the command pins of an SDRAM. While a 3-bit control field holds the programming code (5), a byte write into a fixed address window does not reach the memory as data. It starts a fixed four-cycle command sequence that loads the SDRAM mode register. The sequence is an all-bank precharge, an idle cycle, the mode register set, and a second idle cycle.

The value loaded is taken from the address of the write, not from its data. On an 8-bit memory bus the window offset is the mode value. On a 16-bit bus the offset is twice the mode value, so it is halved before use. The block accepts only values that select a burst length of one with single-location writes. Any other request is refused: the write is acknowledged with an error flag and no command goes out.

The CPU request is held with wait asserted until the last idle cycle of the sequence is over. It is then acknowledged for exactly one cycle. Reads and writes outside the window are acknowledged with no SDRAM command while programming is enabled. When programming is disabled, the block ignores the port.

Top module: `sdram_mode_seq`

## Requirements
- R1: After reset the command pins show NOP ({ras_n,cas_n,we_n} = 3'b111), sd_cke is 1, sd_psel is 0, sd_addr is 0, and cpu_ack, busy and mode_err are 0.
- R2: When prog_ctl is not 3'd5, a request gets no cpu_ack and no SDRAM command, whatever its address.
- R3: On an 8-bit bus (bus16 = 0), a write to window base 0x400000 plus offset X (X below 2^SD_ADDR_W) puts X on sd_addr during the MRS cycle.
- R4: On a 16-bit bus (bus16 = 1), a write to 0x400000 plus offset 2X puts X on sd_addr during the MRS cycle. Offset bit 0 is ignored.
- R5: An accepted write is followed, in the four cycles after its accepting edge, by PALL (3'b010 with sd_psel = 1), NOP (3'b111), MRS (3'b000) and NOP. sd_psel is 1 in no other cycle.
- R6: sd_cke stays 1 in every cycle, including the whole sequence.
- R7: A mode value whose bits [2:0] are not 0 (burst length not one), or whose bit 9 is 0 (burst writes), is refused. On an 8-bit bus, an offset with bit SD_ADDR_W set is also refused. A refused write gets cpu_ack with mode_err = 1 one cycle after acceptance, and no command.
- R8: busy is 1 from the PALL cycle through the trailing NOP. cpu_ack is a one-cycle pulse in the cycle right after that NOP. cpu_wait is 1 while a request is pending without ack.
- R9: With prog_ctl = 3'd5, a read, or a write outside the window, gets cpu_ack one cycle after the request with mode_err = 0 and only NOP on the command pins.
- R10: The mode value is captured at the accepting edge. Later changes of cpu_addr or bus16 during the sequence do not alter the value driven in the MRS cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_ctl | input | 3 | Control field; 3'd5 enables mode programming |
| bus16 | input | 1 | 1 = 16-bit SDRAM bus, 0 = 8-bit |
| cpu_req | input | 1 | Request, held until cpu_ack |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_ack | output | 1 | One-cycle acknowledge |
| cpu_wait | output | 1 | Request pending, not yet acknowledged |
| mode_err | output | 1 | With cpu_ack: requested mode refused |
| busy | output | 1 | Command sequence in progress |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_psel | output | 1 | Precharge-all select (A10) |
| sd_addr | output | SD_ADDR_W | SDRAM address bus |

## Verification
A table of requests is walked one by one, and each is run to its acknowledge. The table mixes 8-bit and 16-bit bus widths with window offsets near both ends of the window. Each mode value has either good or bad burst fields, and some requests are reads or fall outside the window. A 16-bit request with an odd offset shows whether bit 0 is dropped. An 8-bit request whose offset exceeds the mode width shows whether the range check applies only to the narrow bus. Values with wrong burst-length or write-mode bits separate the refusal path from the normal path. Directed tests then cover the reset state and a disabled control field. A final test changes the address and bus width in the middle of a sequence, which separates a captured mode value from one still decoded from the live address.

// File: rtl/sdms_pkg.sv
package sdms_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PALL = 3'd1,
      ST_GAP  = 3'd2,
      ST_LOAD = 3'd3,
      ST_TAIL = 3'd4,
      ST_DONE = 3'd5
   } seq_st_e;

   typedef struct packed {
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_cmd_t;

   localparam sd_cmd_t CMD_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam sd_cmd_t CMD_PALL = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
   localparam sd_cmd_t CMD_MRS  = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

   localparam logic [2:0] CTL_PROG_CODE = 3'd5;
endpackage

// File: rtl/sdms_decode.sv
module sdms_decode #(
   parameter int ADDR_W    = 24,
   parameter int SD_ADDR_W = 13,
   parameter int BL_W      = 3,
   parameter int WB_BIT    = 9,
   parameter logic [ADDR_W-1:0] WIN_BASE = 24'h400000
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 is16,
   output logic                 in_win,
   output logic [SD_ADDR_W-1:0] mode_val,
   output logic                 mode_ok
);
   localparam int OFS_W = SD_ADDR_W + 1;

   logic [OFS_W-1:0] ofs;
   logic             range_ok;
   logic             fmt_ok;

   assign in_win = (addr[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]);
   assign ofs    = addr[OFS_W-1:0];

   always_comb begin
      if (is16) mode_val = ofs[OFS_W-1:1];
      else      mode_val = ofs[SD_ADDR_W-1:0];
   end

   assign range_ok = is16 | ~ofs[OFS_W-1];
   assign fmt_ok   = (mode_val[BL_W-1:0] == '0) && mode_val[WB_BIT];
   assign mode_ok  = range_ok && fmt_ok;
endmodule

// File: rtl/sdms_fsm.sv
module sdms_fsm
   import sdms_pkg::*;
#(
   parameter int SD_ADDR_W = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 req,
   input  logic                 wr,
   input  logic                 in_win,
   input  logic                 mode_ok,
   input  logic [SD_ADDR_W-1:0] mode_in,
   output seq_st_e              state,
   output logic [SD_ADDR_W-1:0] mode_q,
   output logic                 err_q
);
   seq_st_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: begin
            if (req && enable) begin
               if (wr && in_win && mode_ok) nxt = ST_PALL;
               else                         nxt = ST_DONE;
            end
         end
         ST_PALL: nxt = ST_GAP;
         ST_GAP:  nxt = ST_LOAD;
         ST_LOAD: nxt = ST_TAIL;
         ST_TAIL: nxt = ST_DONE;
         ST_DONE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         mode_q <= '0;
         err_q  <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_IDLE && req && enable) begin
            mode_q <= (wr && in_win && mode_ok) ? mode_in : '0;
            err_q  <= wr && in_win && !mode_ok;
         end else if (state == ST_DONE) begin
            mode_q <= '0;
            err_q  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sdms_cmd_drv.sv
module sdms_cmd_drv
   import sdms_pkg::*;
#(
   parameter int SD_ADDR_W = 13,
   parameter bit HOLD_ADDR = 1'b1
) (
   input  seq_st_e              state,
   input  logic [SD_ADDR_W-1:0] mode_q,
   output sd_cmd_t              cmd,
   output logic                 psel,
   output logic [SD_ADDR_W-1:0] addr_out
);
   logic drive_addr;

   always_comb begin
      unique case (state)
         ST_PALL: cmd = CMD_PALL;
         ST_LOAD: cmd = CMD_MRS;
         default: cmd = CMD_NOP;
      endcase
   end

   assign psel = (state == ST_PALL);

   generate
      if (HOLD_ADDR) begin : g_hold
         assign drive_addr = (state == ST_PALL) || (state == ST_GAP) ||
                             (state == ST_LOAD) || (state == ST_TAIL);
      end else begin : g_pulse
         assign drive_addr = (state == ST_LOAD);
      end
   endgenerate

   assign addr_out = drive_addr ? mode_q : '0;
endmodule

// File: rtl/sdram_mode_seq.sv
module sdram_mode_seq
   import sdms_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int SD_ADDR_W = 13,
   parameter int BL_W      = 3,
   parameter int WB_BIT    = 9,
   parameter bit HOLD_ADDR = 1'b1,
   parameter logic [ADDR_W-1:0] WIN_BASE = 24'h400000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           prog_ctl,
   input  logic                 bus16,
   input  logic                 cpu_req,
   input  logic                 cpu_wr,
   input  logic [ADDR_W-1:0]    cpu_addr,
   output logic                 cpu_ack,
   output logic                 cpu_wait,
   output logic                 mode_err,
   output logic                 busy,
   output logic                 sd_ras_n,
   output logic                 sd_cas_n,
   output logic                 sd_we_n,
   output logic                 sd_cke,
   output logic                 sd_psel,
   output logic [SD_ADDR_W-1:0] sd_addr
);
   localparam int OFS_W = SD_ADDR_W + 1;

   generate
      if (OFS_W >= ADDR_W) begin : g_bad_width
         $error("window offset must be narrower than the CPU address");
      end
      if (WB_BIT >= SD_ADDR_W || BL_W < 1 || BL_W > WB_BIT) begin : g_bad_field
         $error("mode field positions do not fit the SDRAM address");
      end
      if (WIN_BASE[OFS_W-1:0] != '0) begin : g_bad_base
         $error("window base must be aligned to the window size");
      end
   endgenerate

   logic                 in_win;
   logic                 mode_ok;
   logic [SD_ADDR_W-1:0] mode_val;
   logic [SD_ADDR_W-1:0] mode_q;
   logic                 err_q;
   seq_st_e              state;
   sd_cmd_t              cmd;

   sdms_decode #(
      .ADDR_W(ADDR_W), .SD_ADDR_W(SD_ADDR_W), .BL_W(BL_W),
      .WB_BIT(WB_BIT), .WIN_BASE(WIN_BASE)
   ) u_decode (
      .addr(cpu_addr), .is16(bus16), .in_win(in_win),
      .mode_val(mode_val), .mode_ok(mode_ok)
   );

   sdms_fsm #(.SD_ADDR_W(SD_ADDR_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .enable(prog_ctl == CTL_PROG_CODE),
      .req(cpu_req), .wr(cpu_wr), .in_win(in_win), .mode_ok(mode_ok),
      .mode_in(mode_val), .state(state), .mode_q(mode_q), .err_q(err_q)
   );

   sdms_cmd_drv #(.SD_ADDR_W(SD_ADDR_W), .HOLD_ADDR(HOLD_ADDR)) u_drv (
      .state(state), .mode_q(mode_q), .cmd(cmd),
      .psel(sd_psel), .addr_out(sd_addr)
   );

   assign sd_ras_n = cmd.ras_n;
   assign sd_cas_n = cmd.cas_n;
   assign sd_we_n  = cmd.we_n;
   assign sd_cke   = 1'b1;
   assign cpu_ack  = (state == ST_DONE);
   assign mode_err = (state == ST_DONE) && err_q;
   assign busy     = (state == ST_PALL) || (state == ST_GAP) ||
                     (state == ST_LOAD) || (state == ST_TAIL);
   assign cpu_wait = cpu_req && !cpu_ack;
endmodule

// File: rtl/sdms_chk.sv
module sdms_chk #(
   parameter int SD_ADDR_W = 13,
   parameter int BL_W      = 3,
   parameter int WB_BIT    = 9
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cpu_ack,
   input logic                 busy,
   input logic                 sd_ras_n,
   input logic                 sd_cas_n,
   input logic                 sd_we_n,
   input logic                 sd_cke,
   input logic                 sd_psel,
   input logic [SD_ADDR_W-1:0] sd_addr
);
   logic is_pall, is_mrs, is_nop;
   assign is_pall = {sd_ras_n, sd_cas_n, sd_we_n} == 3'b010;
   assign is_mrs  = {sd_ras_n, sd_cas_n, sd_we_n} == 3'b000;
   assign is_nop  = {sd_ras_n, sd_cas_n, sd_we_n} == 3'b111;

   assert_cke_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sd_cke);
   assert_pall_psel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_pall |-> sd_psel);
   assert_psel_only_pall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sd_psel |-> is_pall);
   assert_pall_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_pall |=> is_nop ##1 is_mrs ##1 is_nop);
   assert_mrs_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |-> (sd_addr[BL_W-1:0] == '0) && sd_addr[WB_BIT]);
   assert_mrs_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |=> ##1 cpu_ack);
   assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack);
   assert_busy_noack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cpu_ack);
endmodule

bind sdram_mode_seq sdms_chk #(
   .SD_ADDR_W(SD_ADDR_W), .BL_W(BL_W), .WB_BIT(WB_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .busy(busy),
   .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
   .sd_cke(sd_cke), .sd_psel(sd_psel), .sd_addr(sd_addr)
);

// File: tb/sdram_mode_seq_bench.sv
`timescale 1ns/1ps
module sdram_mode_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  prog_ctl = 3'd5;
   logic        bus16 = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [23:0] cpu_addr = '0;
   logic        cpu_ack, cpu_wait, mode_err, busy;
   logic        sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_psel;
   logic [12:0] sd_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sdram_mode_seq u_sdram_mode_seq (
      .clk(clk), .rst_n(rst_n), .prog_ctl(prog_ctl), .bus16(bus16),
      .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_ack(cpu_ack), .cpu_wait(cpu_wait), .mode_err(mode_err),
      .busy(busy), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
      .sd_we_n(sd_we_n), .sd_cke(sd_cke), .sd_psel(sd_psel),
      .sd_addr(sd_addr)
   );

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [2:0] cmd_now();
      return {sd_ras_n, sd_cas_n, sd_we_n};
   endfunction

   // vector: {bus16, wr, kind[1:0], addr[23:0], x[12:0]}; kind 0=seq 1=refused 2=plain ack
   localparam int NV = 11;
   localparam logic [40:0] VEC [NV] = '{
      {1'b0, 1'b1, 2'd0, 24'h400200, 13'h0200},   // R3
      {1'b0, 1'b1, 2'd0, 24'h400230, 13'h0230},   // R3
      {1'b1, 1'b1, 2'd0, 24'h400460, 13'h0230},   // R4
      {1'b1, 1'b1, 2'd0, 24'h400461, 13'h0230},   // R4 bit0 ignored
      {1'b0, 1'b1, 2'd1, 24'h400201, 13'h0000},   // R7 burst length
      {1'b0, 1'b1, 2'd1, 24'h400030, 13'h0000},   // R7 write mode
      {1'b0, 1'b1, 2'd1, 24'h402200, 13'h0000},   // R7 range on 8-bit
      {1'b1, 1'b1, 2'd0, 24'h403FF0, 13'h1FF8},   // R4 top of window
      {1'b0, 1'b0, 2'd2, 24'h400200, 13'h0000},   // R9 read
      {1'b0, 1'b1, 2'd2, 24'h300200, 13'h0000},   // R9 outside
      {1'b1, 1'b1, 2'd2, 24'h404000, 13'h0000}    // R9 just past window
   };

   task automatic run_vec(input logic [40:0] v);
      logic [1:0]  kind;
      logic [12:0] x;
      kind = v[38:37];
      x    = v[12:0];
      @(negedge clk);
      bus16    = v[40];
      cpu_wr   = v[39];
      cpu_addr = v[36:13];
      cpu_req  = 1'b1;
      #0.1 chk("R8", "wait on request", cpu_wait, 1);
      @(negedge clk);
      if (kind == 2'd0) begin
         chk("R5", "PALL cmd", cmd_now(), 3'b010);
         chk("R5", "PALL psel", sd_psel, 1);
         chk("R8", "busy PALL", busy, 1);
         chk("R6", "cke", sd_cke, 1);
         @(negedge clk);
         chk("R5", "gap NOP", cmd_now(), 3'b111);
         chk("R5", "psel gap", sd_psel, 0);
         @(negedge clk);
         chk("R5", "MRS cmd", cmd_now(), 3'b000);
         chk(v[40] ? "R4" : "R3", "MRS addr", sd_addr, x);
         chk("R8", "wait in MRS", cpu_wait, 1);
         @(negedge clk);
         chk("R5", "tail NOP", cmd_now(), 3'b111);
         chk("R8", "busy tail", busy, 1);
         chk("R8", "no ack tail", cpu_ack, 0);
         @(negedge clk);
         chk("R8", "ack", cpu_ack, 1);
         chk("R8", "busy after", busy, 0);
         chk("R7", "no err", mode_err, 0);
      end else begin
         chk(kind == 2'd1 ? "R7" : "R9", "ack", cpu_ack, 1);
         chk(kind == 2'd1 ? "R7" : "R9", "err", mode_err, kind == 2'd1);
         chk(kind == 2'd1 ? "R7" : "R9", "cmd", cmd_now(), 3'b111);
         chk(kind == 2'd1 ? "R7" : "R9", "busy", busy, 0);
      end
      cpu_req = 1'b0;
      @(negedge clk);
      chk("R8", "ack one cycle", cpu_ack, 0);
      chk("R5", "idle NOP", cmd_now(), 3'b111);
   endtask

   initial begin
      #50000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset cmd", cmd_now(), 3'b111);
      chk("R1", "reset cke", sd_cke, 1);
      chk("R1", "reset psel", sd_psel, 0);
      chk("R1", "reset addr", sd_addr, 0);
      chk("R1", "reset ack", cpu_ack, 0);
      chk("R1", "reset busy", busy, 0);
      chk("R1", "reset err", mode_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "idle after reset", cmd_now(), 3'b111);

      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R2: disabled control field ignores a valid window write
      prog_ctl = 3'd4;
      bus16 = 1'b0; cpu_wr = 1'b1; cpu_addr = 24'h400200; cpu_req = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk("R2", "no ack", cpu_ack, 0);
         chk("R2", "no cmd", cmd_now(), 3'b111);
      end
      cpu_req = 1'b0;
      prog_ctl = 3'd5;
      @(negedge clk);

      // R10: address and width change mid-sequence
      bus16 = 1'b0; cpu_wr = 1'b1; cpu_addr = 24'h400A00; cpu_req = 1'b1;
      @(negedge clk);
      chk("R10", "PALL", cmd_now(), 3'b010);
      cpu_addr = 24'h400208;
      bus16 = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R10", "MRS cmd", cmd_now(), 3'b000);
      chk("R10", "MRS held value", sd_addr, 13'h0A00);
      @(negedge clk);
      @(negedge clk);
      chk("R10", "ack", cpu_ack, 1);
      cpu_req = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule